// File: doc/BRIEF.md
# Dual-Counter Multi-Mode Timer

The block is a timer peripheral built around two 16-bit down-counters and two 16-bit holding registers. The same hardware serves four operating modes: a self-running pulse generator that drives pin TA with programmed high and low times; a dual capture mode that records the first counter's value on rising edges of TA and TB; a pair of independent auto-reloading timers; and a mixed mode with one capture channel and one reloading timer. A 2-bit mode field selects the mode.

Each counter has its own clock selector. The selector picks one of four sources: stopped, a shared prescaled system clock, synchronized rising edges on TB, or system cycles counted while TB is high. The prescaler is a 5-bit counter. It produces one enable pulse each time it reaches the programmed limit and then clears. Both pins pass through a two-stage synchronizer before any use. Software reaches the block through a flat eight-register write/read interface. Two pending bits record underflow and capture events, and a single interrupt line is raised while any enabled pending bit is set.

Register map (word addresses): 0 counter 1, 1 counter 2, 2 holding register A, 3 holding register B, 4 prescaler limit [4:0], 5 control {sel2[5:4], sel1[3:2], mode[1:0]}, 6 interrupt enable [1:0], 7 pending [1:0]. Mode codes: 0 pulse generator, 1 dual capture, 2 dual timer, 3 capture plus timer. Clock select codes: 0 stopped, 1 prescaled, 2 TB event, 3 TB-gated accumulate.

Top module: `multimode_timer`

## Requirements
- R1: After reset all eight registers read 0, ta_o is 0, irq_o is 0, and ta_oe_o is 1 because mode 0 is selected.
- R2: With clock select 1 and prescaler limit P (0..31), the counter decrements exactly once every P+1 system cycles.
- R3: Clock select 2 decrements once per synchronized rising edge of tb_i. Clock select 3 decrements once per cycle while synchronized tb_i is high. Clock select 0 leaves the counter unchanged whatever tb_i does.
- R4: In mode 0, every underflow of counter 1 toggles ta_o. The counter reloads from register A when ta_o goes high and from register B when it goes low, so the high time is (A+1) ticks and the low time is (B+1) ticks. ta_oe_o is 1 only in mode 0.
- R5: In mode 1, a rising edge on ta_i copies counter 1 into register A and sets pending bit 0. A rising edge on tb_i copies counter 1 into register B and sets pending bit 1. Two edges spaced N cycles apart at prescaler limit 0 leave A-B equal to N.
- R6: In mode 2, counter 1 reloads from A on underflow and sets pending bit 0. Counter 2 reloads from B on underflow and sets pending bit 1. A counter that is not reloading wraps from 0 to 0xFFFF.
- R7: In mode 3, a rising edge on ta_i copies counter 1 into A and sets pending bit 0. Counter 2 reloads from B and sets pending bit 1.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins. irq_o is 1 exactly while some pending bit with its enable bit set is 1.
- R9: A mode write takes effect only if both clock selects are stopped when it is written. A clock-select write takes effect only if that select is currently stopped or the new value is stop. Any other such write leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| ta_i | input | 1 | Pin A input (capture source) |
| tb_i | input | 1 | Pin B input (capture, event or gate source) |
| ta_o | output | 1 | Pin A output level in pulse mode |
| ta_oe_o | output | 1 | Pin A output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that a bus write is a single-cycle strobe with a stable address and data, and that ta_i and tb_i are free of glitches between the synchronizer stages. The event and capture properties also assume that pin edges are at least four system cycles apart, since closer edges can merge in the synchronizer. The stimulus changes pins and bus signals only just after a rising clock edge, and it keeps every pin high or low phase at two or more cycles so that edges stay at least four cycles apart. It reconfigures the mode or a clock source only after writing stop.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MODE_PULSE  = 2'd0,
    MODE_DCAP   = 2'd1,
    MODE_DTIMER = 2'd2,
    MODE_CAPTMR = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    CS_STOP  = 2'd0,
    CS_PRESC = 2'd1,
    CS_EVENT = 2'd2,
    CS_ACCUM = 2'd3
  } clksel_e;

  localparam logic [2:0] A_CNT1 = 3'd0;
  localparam logic [2:0] A_CNT2 = 3'd1;
  localparam logic [2:0] A_HLDA = 3'd2;
  localparam logic [2:0] A_HLDB = 3'd3;
  localparam logic [2:0] A_PRSC = 3'd4;
  localparam logic [2:0] A_CTRL = 3'd5;
  localparam logic [2:0] A_IEN  = 3'd6;
  localparam logic [2:0] A_PEND = 3'd7;
endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] limit_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mmt_sync.sv
module mmt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         rl_en_i,
  input  logic [W-1:0] rl_val_i,
  output logic [W-1:0] cnt_o,
  output logic         uflow_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o   = cnt_q;
  assign uflow_o = tick_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (ld_i)    cnt_q <= ld_val_i;
    else if (tick_i) begin
      if (cnt_q == '0) cnt_q <= rl_en_i ? rl_val_i : '1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i && cnt_q == '0 && rl_en_i) |=> (cnt_q == $past(rl_val_i)));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import mmt_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_we_i,
  input  logic [2:0]   bus_addr_i,
  input  logic [W-1:0] bus_wdata_i,
  output logic [W-1:0] bus_rdata_o,
  input  logic         ta_i,
  input  logic         tb_i,
  output logic         ta_o,
  output logic         ta_oe_o,
  output logic         irq_o
);
  localparam int NCNT = 2;

  logic [PW-1:0] prsc_q;
  mode_e         mode_q;
  clksel_e       sel_q [NCNT];
  logic [W-1:0]  hld_a_q, hld_b_q;
  logic [1:0]    ien_q, pend_q;
  logic          ta_q;

  logic          ptick;
  logic [1:0]    pin_raw, pin_lvl, pin_rise;
  logic [NCNT-1:0][W-1:0] cnt, rl_val;
  logic [NCNT-1:0] tick, ld, rl_en, uf;
  logic          cap_a, cap_b;
  logic [1:0]    set_pend, clr_pend;

  mmt_prescaler #(.PW(PW)) i_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .limit_i(prsc_q), .tick_o(ptick));

  assign pin_raw = {tb_i, ta_i};
  for (genvar p = 0; p < 2; p++) begin : g_sync
    mmt_sync #(.STAGES(2)) i_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_raw[p]),
      .lvl_o(pin_lvl[p]), .rise_o(pin_rise[p]));
  end

  function automatic logic pick_tick(clksel_e s, logic pt, logic ev, logic lv);
    case (s)
      CS_PRESC: return pt;
      CS_EVENT: return ev;
      CS_ACCUM: return lv;
      default:  return 1'b0;
    endcase
  endfunction

  assign rl_en[0]  = (mode_q == MODE_PULSE) || (mode_q == MODE_DTIMER);
  assign rl_en[1]  = (mode_q == MODE_DTIMER) || (mode_q == MODE_CAPTMR);
  // pulse mode: ta low now means it goes high next, so load the high time
  assign rl_val[0] = (mode_q == MODE_PULSE && ta_q) ? hld_b_q : hld_a_q;
  assign rl_val[1] = hld_b_q;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign tick[i] = pick_tick(sel_q[i], ptick, pin_rise[1], pin_lvl[1]);
    assign ld[i]   = bus_we_i && (bus_addr_i == A_CNT1 + 3'(i));
    mmt_counter #(.W(W)) i_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick[i]), .ld_i(ld[i]),
      .ld_val_i(bus_wdata_i), .rl_en_i(rl_en[i]), .rl_val_i(rl_val[i]),
      .cnt_o(cnt[i]), .uflow_o(uf[i]));
  end

  assign cap_a = pin_rise[0] && (mode_q == MODE_DCAP || mode_q == MODE_CAPTMR);
  assign cap_b = pin_rise[1] && (mode_q == MODE_DCAP);

  assign set_pend[0] = cap_a | (uf[0] & rl_en[0]);
  assign set_pend[1] = cap_b | (uf[1] & (mode_q != MODE_DCAP));
  assign clr_pend    = (bus_we_i && bus_addr_i == A_PEND) ? bus_wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hld_a_q <= '0;
      hld_b_q <= '0;
      prsc_q  <= '0;
      ien_q   <= '0;
      pend_q  <= '0;
      ta_q    <= 1'b0;
    end else begin
      if (bus_we_i && bus_addr_i == A_HLDA) hld_a_q <= bus_wdata_i;
      else if (cap_a)                       hld_a_q <= cnt[0];
      if (bus_we_i && bus_addr_i == A_HLDB) hld_b_q <= bus_wdata_i;
      else if (cap_b)                       hld_b_q <= cnt[0];
      if (bus_we_i && bus_addr_i == A_PRSC) prsc_q <= bus_wdata_i[PW-1:0];
      if (bus_we_i && bus_addr_i == A_IEN)  ien_q  <= bus_wdata_i[1:0];
      pend_q <= (pend_q & ~clr_pend) | set_pend;
      if (mode_q == MODE_PULSE && uf[0]) ta_q <= ~ta_q;
    end
  end

  // control: mode needs both sources stopped; a source may always be stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_PULSE;
      sel_q[0] <= CS_STOP;
      sel_q[1] <= CS_STOP;
    end else if (bus_we_i && bus_addr_i == A_CTRL) begin
      if (sel_q[0] == CS_STOP && sel_q[1] == CS_STOP)
        mode_q <= mode_e'(bus_wdata_i[1:0]);
      for (int i = 0; i < NCNT; i++) begin
        if (sel_q[i] == CS_STOP || bus_wdata_i[2+2*i +: 2] == 2'b00)
          sel_q[i] <= clksel_e'(bus_wdata_i[2+2*i +: 2]);
      end
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_CNT1:  bus_rdata_o = cnt[0];
      A_CNT2:  bus_rdata_o = cnt[1];
      A_HLDA:  bus_rdata_o = hld_a_q;
      A_HLDB:  bus_rdata_o = hld_b_q;
      A_PRSC:  bus_rdata_o = W'(prsc_q);
      A_CTRL:  bus_rdata_o = W'({sel_q[1], sel_q[0], mode_q});
      A_IEN:   bus_rdata_o = W'(ien_q);
      default: bus_rdata_o = W'(pend_q);
    endcase
  end

  assign ta_o    = ta_q;
  assign ta_oe_o = (mode_q == MODE_PULSE);
  assign irq_o   = |(pend_q & ien_q);

  assert_mode_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q[0] != CS_STOP || sel_q[1] != CS_STOP) |=> (mode_q == $past(mode_q)));
  assert_pulse_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PULSE && uf[0]) |=> (ta_o != $past(ta_o)));
  assert_pend_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pend[0] && !set_pend[0]) |=> !pend_q[0]);
  assert_capture_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_a && !(bus_we_i && bus_addr_i == A_HLDA)) |=> (hld_a_q == $past(cnt[0])));
endmodule

// File: tb/test_multimode_timer.sv
module test_multimode_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ta = 1'b0, tb = 1'b0;
  logic        ta_o, ta_oe_o, irq_o;

  int checks = 0, fails = 0;

  multimode_timer i_multimode_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ta_i(ta), .tb_i(tb),
    .ta_o(ta_o), .ta_oe_o(ta_oe_o), .irq_o(irq_o));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_c1, m_c2, m_ra, m_rb, m_prsc, m_mode, m_s1, m_s2, m_ien, m_pend, m_ta, m_pre;
  int sa1, sa2, sa3, sb1, sb2, sb3;

  function automatic int src_tick(int s, int pt, int ev, int lv);
    if (s == 1) return pt;
    if (s == 2) return ev;
    if (s == 3) return lv;
    return 0;
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return m_c1;
      1: return m_c2;
      2: return m_ra;
      3: return m_rb;
      4: return m_prsc;
      5: return (m_s2 << 4) | (m_s1 << 2) | m_mode;
      6: return m_ien;
      default: return m_pend;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c1 = 0; m_c2 = 0; m_ra = 0; m_rb = 0; m_prsc = 0; m_mode = 0; m_s1 = 0; m_s2 = 0;
      m_ien = 0; m_pend = 0; m_ta = 0; m_pre = 0;
      sa1 = 0; sa2 = 0; sa3 = 0; sb1 = 0; sb2 = 0; sb3 = 0;
    end else begin
      int ea, eb, pt, t1, t2, u1, u2, n_c1, n_c2, n_ra, n_rb, n_ta, n_pend, clr, setp;
      int n_mode, n_s1, n_s2, w1, w2;
      ea = (sa2 && !sa3); eb = (sb2 && !sb3); pt = (m_pre == m_prsc);
      t1 = src_tick(m_s1, pt, eb, sb2);
      t2 = src_tick(m_s2, pt, eb, sb2);
      u1 = t1 && m_c1 == 0;
      u2 = t2 && m_c2 == 0;
      n_c1 = m_c1; n_c2 = m_c2;
      if (t1) n_c1 = u1 ? (m_mode == 0 ? (m_ta ? m_rb : m_ra) : (m_mode == 2 ? m_ra : 65535)) : m_c1 - 1;
      if (t2) n_c2 = u2 ? (m_mode >= 2 ? m_rb : 65535) : m_c2 - 1;
      n_ta = (m_mode == 0 && u1) ? !m_ta : m_ta;
      n_ra = (ea && (m_mode == 1 || m_mode == 3)) ? m_c1 : m_ra;
      n_rb = (eb && m_mode == 1) ? m_c1 : m_rb;
      setp = ((ea && (m_mode == 1 || m_mode == 3)) || (u1 && (m_mode == 0 || m_mode == 2)))
           | (((eb && m_mode == 1) || (u2 && m_mode != 1)) << 1);
      clr = 0; n_mode = m_mode; n_s1 = m_s1; n_s2 = m_s2;
      if (we) begin
        case (addr)
          0: n_c1 = wdata;
          1: n_c2 = wdata;
          2: n_ra = wdata;
          3: n_rb = wdata;
          4: m_prsc = wdata & 31;
          5: begin
            w1 = (wdata >> 2) & 3; w2 = (wdata >> 4) & 3;
            if (m_s1 == 0 && m_s2 == 0) n_mode = wdata & 3;
            if (m_s1 == 0 || w1 == 0) n_s1 = w1;
            if (m_s2 == 0 || w2 == 0) n_s2 = w2;
          end
          6: m_ien = wdata & 3;
          default: clr = wdata & 3;
        endcase
      end
      n_pend = (m_pend & ~clr) | setp;
      m_pre = pt ? 0 : (m_pre + 1) % 32;
      m_c1 = n_c1; m_c2 = n_c2; m_ra = n_ra; m_rb = n_rb; m_ta = n_ta; m_pend = n_pend;
      m_mode = n_mode; m_s1 = n_s1; m_s2 = n_s2;
      sa3 = sa2; sa2 = sa1; sa1 = ta;
      sb3 = sb2; sb2 = sb1; sb1 = tb;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rdata == 16'(exp_rd(addr)), "R6", rdata, exp_rd(addr), "model rdata");
      chk(ta_o == m_ta[0], "R4", ta_o, m_ta, "model ta_o");
      chk(ta_oe_o == (m_mode == 0), "R4", ta_oe_o, m_mode == 0, "model ta_oe_o");
      chk(irq_o == ((m_pend & m_ien) != 0), "R8", irq_o, (m_pend & m_ien) != 0, "model irq_o");
    end
  end

  // stimulus tasks: all leave time just after a rising edge
  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(int a, int d);
    we = 1'b1; addr = 3'(a); wdata = 16'(d); step(); we = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) begin addr = addr + 3'd1; step(); end
  endtask
  task automatic hold(int n); repeat (n) step(); endtask
  task automatic rd(int a, output int v);
    addr = 3'(a); @(negedge clk); v = rdata; step();
  endtask

  task automatic cnt_period(output int n);
    int prev;
    n = 0;
    addr = 3'd0;
    @(negedge clk); prev = rdata;
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (rdata != prev) break; end
    prev = rdata;
    for (int k = 0; k < 200; k++) begin @(negedge clk); n++; if (rdata != prev) break; end
    step();
  endtask

  task automatic pulse_times(output int hi, output int lo);
    hi = 0; lo = 0;
    for (int k = 0; k < 500; k++) begin @(negedge clk); if (!ta_o) break; end
    for (int k = 0; k < 500; k++) begin @(negedge clk); if (ta_o) break; end
    for (int k = 0; k < 500; k++) begin @(negedge clk); hi++; if (!ta_o) break; end
    for (int k = 0; k < 500; k++) begin @(negedge clk); lo++; if (ta_o) break; end
    step();
  endtask

  task automatic capture_pair(int gap, int tag3);
    int va, vb, vp;
    wr(7, 3);
    hold(5);
    ta = 1'b1; hold(3); ta = 1'b0; hold(gap - 3);
    tb = 1'b1; hold(3); tb = 1'b0; hold(6);
    rd(2, va); rd(3, vb); rd(7, vp);
    if (tag3) begin
      chk(vp == 1, "R7", vp, 1, "pending after ta capture");
      chk(va != 0, "R7", va, 1, "A captured");
    end else begin
      chk(va - vb == gap, "R5", va - vb, gap, "capture spacing");
      chk(vp == 3, "R5", vp, 3, "capture pending bits");
    end
  endtask

  initial begin : wd
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1, "timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int v, hi, lo;
    hold(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk(v == 0, "R1", v, 0, "register after reset");
    end
    chk(ta_o == 0 && irq_o == 0 && ta_oe_o == 1, "R1", {ta_o, irq_o, ta_oe_o}, 1, "pins after reset");

    // R9 control write rules
    wr(5, 'h04); rd(5, v); chk(v == 'h04, "R9", v, 'h04, "select from stop");
    wr(5, 'h06); rd(5, v); chk(v == 'h04, "R9", v, 'h04, "mode ignored while running");
    wr(5, 'h08); rd(5, v); chk(v == 'h04, "R9", v, 'h04, "select change ignored while running");
    wr(5, 'h00); rd(5, v); chk(v == 'h00, "R9", v, 0, "stop accepted");

    // R2 prescaler ratios 1..32
    wr(5, 'h02); wr(2, 'hFFFF);
    for (int p = 0; p < 32; p++) begin
      wr(5, 'h02); wr(4, p); wr(0, 1000); wr(5, 'h06);
      cnt_period(v);
      chk(v == p + 1, "R2", v, p + 1, "prescaler period");
    end

    // R4 pulse generator
    wr(5, 'h02); wr(5, 'h00); wr(4, 0); wr(2, 3); wr(3, 5); wr(0, 0); wr(5, 'h04);
    pulse_times(hi, lo);
    chk(hi == 4, "R4", hi, 4, "high time");
    chk(lo == 6, "R4", lo, 6, "low time");
    chk(ta_oe_o == 1, "R4", ta_oe_o, 1, "output enabled");
    wr(5, 'h00); wr(4, 2); wr(5, 'h04);
    pulse_times(hi, lo);
    chk(hi == 12, "R4", hi, 12, "high time prescaled");
    chk(lo == 18, "R4", lo, 18, "low time prescaled");
    wr(5, 'h00);

    // R5 dual capture
    wr(4, 0); wr(5, 'h01); wr(5, 'h05); wr(0, 5000);
    chk(ta_oe_o == 0, "R4", ta_oe_o, 0, "output disabled outside pulse mode");
    capture_pair(37, 0);
    capture_pair(100, 0);
    wr(5, 'h01);

    // R7 capture plus timer
    wr(5, 'h03); wr(3, 6); wr(1, 6); wr(0, 4000); wr(5, 'h17);
    wr(7, 3);
    ta = 1'b1; hold(3); ta = 1'b0; hold(4);
    rd(7, v); chk((v & 1) == 1, "R7", v, 1, "ta capture pending");
    rd(2, v); chk(v < 4000 && v > 3980, "R7", v, 3990, "A holds captured count");
    addr = 3'd1;
    for (int k = 0; k < 50; k++) begin @(negedge clk); if (rdata == 0) break; end
    @(negedge clk); chk(rdata == 6, "R7", rdata, 6, "counter 2 reload");
    step();
    wr(5, 'h03);

    // R6 dual timer
    wr(5, 'h02); wr(2, 9); wr(3, 4); wr(0, 9); wr(1, 4); wr(7, 3); wr(6, 1); wr(5, 'h16);
    idle(25);
    rd(7, v); chk(v == 3, "R6", v, 3, "both underflows pending");
    chk(irq_o == 1, "R8", irq_o, 1, "irq with enabled pending");
    addr = 3'd1;
    for (int k = 0; k < 50; k++) begin @(negedge clk); if (rdata == 0) break; end
    @(negedge clk); chk(rdata == 4, "R6", rdata, 4, "counter 2 reload from B");
    step();

    // R8 pending clear and irq gating
    wr(5, 'h02);
    wr(7, 1); rd(7, v); chk(v == 2, "R8", v, 2, "write-one clears bit 0 only");
    chk(irq_o == 0, "R8", irq_o, 0, "irq off with bit 0 cleared");
    wr(6, 3); hold(1); chk(irq_o == 1, "R8", irq_o, 1, "irq on with bit 1 enabled");
    wr(7, 0); rd(7, v); chk(v == 2, "R8", v, 2, "write zero no effect");
    wr(7, 2); hold(1); chk(irq_o == 0, "R8", irq_o, 0, "irq off after clear");

    // R3 event, accumulate and stop
    wr(0, 500); wr(5, 'h0A);
    repeat (6) begin tb = 1'b1; hold(2); tb = 1'b0; hold(2); end
    hold(4);
    rd(0, v); chk(v == 494, "R3", v, 494, "event count");
    wr(5, 'h02); wr(0, 500); wr(5, 'h0E);
    tb = 1'b1; hold(10); tb = 1'b0; hold(5);
    rd(0, v); chk(v == 490, "R3", v, 490, "gated accumulate");
    wr(5, 'h02);
    repeat (3) begin tb = 1'b1; hold(3); tb = 1'b0; hold(3); end
    rd(0, v); chk(v == 490, "R3", v, 490, "stopped source ignores tb");

    idle(8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule